// File: doc/BRIEF.md
# Serial LED Command Packet Decoder

This block listens to a two-wire serial stream made of a data line and a clock line, with no select line. It turns each packet into writes on a staging bank that holds 24 seven-bit dimming values. Both lines are brought into the system clock through two-flop synchronisers. Bits are taken most significant first on rising serial-clock edges. A byte is released on the falling edge that ends its eighth bit.

Packets are framed by reserved byte values. The value 0xFF opens a packet from any state. The next byte is a device address, which is compared against a 6-bit identity input or which calls every device. Channel selector and duty byte pairs follow. A selector can also write one duty byte to the whole bank, or open a burst in which the following duty bytes fill the channels in order. The value 0x81 closes the packet and raises a one-cycle apply request, which tells the downstream dimming logic to take the staged values.

The packet state machine has these states. ST_IDLE waits for a start byte. ST_ADDR takes the address byte. ST_SUB takes a channel selector. ST_DATA takes a duty byte. ST_DROP discards the duty byte that follows a bad selector. ST_BURST takes sequential duty bytes. ST_IGNORE holds after an address miss. A start byte moves any state to ST_ADDR. An address hit moves ST_ADDR to ST_SUB, and a miss moves it to ST_IGNORE. In ST_SUB, a channel or all-channel selector leads to ST_DATA, the burst selector leads to ST_BURST, and any other value leads to ST_DROP. ST_DATA and ST_DROP both return to ST_SUB. An end byte seen in ST_ADDR, ST_SUB, ST_DATA, ST_DROP or ST_BURST requests an apply and goes to ST_IDLE.

Top module: `ledpkt_decoder`

## Requirements
- R1: Each rising serial-clock edge shifts in one data bit, most significant bit first. The byte is handed on at the falling edge that ends its eighth bit. The resulting write or apply request shows at the ports on the fourth system-clock edge after that falling edge reaches the input.
- R2: Byte 0xFF restarts parsing from any state, including burst. The next byte is treated as a device address, and a burst in progress stops.
- R3: An address byte hits when bit 7 is 0 and either bit 0 is 1 (call to all devices) or bits 6:1 equal `dev_id`. After a miss, every byte other than 0xFF is ignored: there are no writes and no apply request.
- R4: Selector value (n+1)<<1, for n from 0 to 23, picks channel n, where channel n occupies `duty_flat[7n+6:7n]`. The following duty byte, with bit 0 equal to 0, stores bits 7:1 into that channel.
- R5: Selector 0x40 stores the following duty byte into all 24 channels.
- R6: Selector 0x60 starts a burst. Successive duty bytes go to channels 0, 1, 2 and so on. Bytes after the 24th are ignored. Channels not reached keep their values.
- R7: One address may be followed by several selector and duty pairs before the end byte.
- R8: Byte 0x81 inside an open packet gives exactly one cycle of `apply_req` and closes the packet. Bytes that follow, up to the next 0xFF, change nothing.
- R9: A selector outside the listed values drops the byte after it. A duty byte with bit 0 set is dropped. Neither of these writes anything.
- R10: After reset, every channel reads 0 and `apply_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock, asynchronous to clk |
| sda_in | input | 1 | Serial data, asynchronous to clk |
| dev_id | input | 6 | Identity compared with address bits 6:1 |
| duty_flat | output | 168 | Staged duty values, channel n in bits 7n+6:7n |
| apply_req | output | 1 | One-cycle request to apply staged values |

## Verification
A wrong packet state shows at the staging outputs as soon as the next duty byte lands, which is four system clocks after its last serial-clock fall. The symptom is a channel written with a value that should have been skipped, or a channel left unchanged when it should have been written. A wrong parse state also shows as a missing or extra `apply_req` pulse when the end byte arrives. An error in the burst position or in byte alignment spreads across neighbouring channels, so comparing the full bank against a reference on every clock catches it within one byte.

// File: rtl/ledpkt_pkg.sv
package ledpkt_pkg;
    localparam logic [7:0] CODE_START = 8'hFF;
    localparam logic [7:0] CODE_END   = 8'h81;
    localparam logic [7:0] CODE_ALL   = 8'h40;
    localparam logic [7:0] CODE_BURST = 8'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_DROP,
        ST_BURST,
        ST_IGNORE
    } pkt_state_t;
endpackage

// File: rtl/ledpkt_serial_rx.sv
module ledpkt_serial_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sda_in,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [SYNC_STAGES-1:0] sclk_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   sclk_d;
    logic [BYTE_W-1:0]      shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   sclk_s, sda_s, rise, fall;

    assign sclk_s = sclk_sync[SYNC_STAGES-1];
    assign sda_s  = sda_sync[SYNC_STAGES-1];
    assign rise   = sclk_s & ~sclk_d;
    assign fall   = ~sclk_s & sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            sda_sync  <= '0;
            sclk_d    <= 1'b0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_in};
            sda_sync  <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            sclk_d    <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (rise) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
                if (bit_cnt != CNT_W'(BYTE_W))
                    bit_cnt <= bit_cnt + 1'b1;
            end else if (fall && bit_cnt == CNT_W'(BYTE_W)) begin
                byte_valid <= 1'b1;
                byte_data  <= shreg;
                bit_cnt    <= '0;
            end
        end
    end

    // R1: a byte is released for a single cycle only
    assert_byte_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    // R1: the bit counter never passes one byte
    assert_bitcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/ledpkt_fsm.sv
module ledpkt_fsm
    import ledpkt_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int ID_W   = 6,
    parameter int DUTY_W = 7,
    parameter int IDX_W  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [ID_W-1:0]   dev_id,
    output logic              wr_en,
    output logic              wr_all,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DUTY_W-1:0] wr_val,
    output logic              apply_set
);
    pkt_state_t       state, state_nx;
    logic             sel_all, sel_all_nx;
    logic [IDX_W-1:0] sel_idx, sel_idx_nx;

    logic       is_start, is_end, addr_hit, sub_chan, duty_ok, in_packet;
    logic [4:0] sub_field;

    assign is_start  = byte_data == CODE_START;
    assign is_end    = byte_data == CODE_END;
    assign addr_hit  = !byte_data[7] && (byte_data[0] || byte_data[ID_W:1] == dev_id);
    assign sub_field = byte_data[5:1];
    assign sub_chan  = byte_data[7:6] == 2'b00 && !byte_data[0] &&
                       sub_field != 5'd0 && 32'(sub_field) <= NUM_CH;
    assign duty_ok   = !byte_data[0];
    assign in_packet = state != ST_IDLE && state != ST_IGNORE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_all <= 1'b0;
            sel_idx <= '0;
        end else begin
            state   <= state_nx;
            sel_all <= sel_all_nx;
            sel_idx <= sel_idx_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        sel_all_nx = sel_all;
        sel_idx_nx = sel_idx;
        if (byte_valid) begin
            if (is_start) begin
                state_nx = ST_ADDR;
            end else if (is_end && in_packet) begin
                state_nx = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: state_nx = state;
                    ST_ADDR: state_nx = addr_hit ? ST_SUB : ST_IGNORE;
                    ST_SUB: begin
                        if (sub_chan) begin
                            state_nx   = ST_DATA;
                            sel_all_nx = 1'b0;
                            sel_idx_nx = IDX_W'(sub_field - 5'd1);
                        end else if (byte_data == CODE_ALL) begin
                            state_nx   = ST_DATA;
                            sel_all_nx = 1'b1;
                        end else if (byte_data == CODE_BURST) begin
                            state_nx   = ST_BURST;
                            sel_all_nx = 1'b0;
                            sel_idx_nx = '0;
                        end else begin
                            state_nx = ST_DROP;
                        end
                    end
                    ST_DATA, ST_DROP: state_nx = ST_SUB;
                    ST_BURST: begin
                        if (duty_ok && 32'(sel_idx) < NUM_CH)
                            sel_idx_nx = sel_idx + 1'b1;
                    end
                    default: state_nx = ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        wr_en     = 1'b0;
        wr_all    = 1'b0;
        wr_idx    = sel_idx;
        wr_val    = byte_data[7:1];
        apply_set = byte_valid && is_end && in_packet;
        if (byte_valid && !is_start && duty_ok) begin
            unique case (state)
                ST_DATA: begin
                    wr_en  = 1'b1;
                    wr_all = sel_all;
                end
                ST_BURST: wr_en = 32'(sel_idx) < NUM_CH;
                default:  wr_en = 1'b0;
            endcase
        end
    end

    // R3: no activity while an address miss is in force
    assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !wr_en && !apply_set);
    // R6: the burst position stays within the bank
    assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_idx) <= NUM_CH);
    // R4: a single-channel write always names a real channel
    assert_write_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_all |-> 32'(wr_idx) < NUM_CH);
    // R8: an apply request closes the packet
    assert_end_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_set |=> state == ST_IDLE);
    // R2: a start byte always leads to address parsing
    assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_data == CODE_START |=> state == ST_ADDR);
endmodule

// File: rtl/ledpkt_stage.sv
module ledpkt_stage #(
    parameter int NUM_CH = 24,
    parameter int DUTY_W = 7,
    parameter int IDX_W  = $clog2(NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_all,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DUTY_W-1:0]        wr_val,
    input  logic                     apply_set,
    output logic [NUM_CH*DUTY_W-1:0] duty_flat,
    output logic                     apply_req
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [DUTY_W-1:0] duty_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                duty_q <= '0;
            else if (wr_en && (wr_all || wr_idx == IDX_W'(g)))
                duty_q <= wr_val;
        end
        assign duty_flat[g*DUTY_W +: DUTY_W] = duty_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) apply_req <= 1'b0;
        else        apply_req <= apply_set;
    end

    // R8: the apply request lasts one cycle
    assert_apply_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_req |=> !apply_req);
endmodule

// File: rtl/ledpkt_decoder.sv
module ledpkt_decoder #(
    parameter int NUM_CH = 24,
    parameter int ID_W   = 6,
    parameter int DUTY_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_in,
    input  logic                     sda_in,
    input  logic [ID_W-1:0]          dev_id,
    output logic [NUM_CH*DUTY_W-1:0] duty_flat,
    output logic                     apply_req
);
    localparam int IDX_W = $clog2(NUM_CH + 1);

    logic              byte_valid;
    logic [7:0]        byte_data;
    logic              wr_en, wr_all, apply_set;
    logic [IDX_W-1:0]  wr_idx;
    logic [DUTY_W-1:0] wr_val;

    ledpkt_serial_rx #(.BYTE_W(8), .SYNC_STAGES(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sda_in(sda_in),
        .byte_valid(byte_valid), .byte_data(byte_data)
    );

    ledpkt_fsm #(.NUM_CH(NUM_CH), .ID_W(ID_W), .DUTY_W(DUTY_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .dev_id(dev_id), .wr_en(wr_en), .wr_all(wr_all), .wr_idx(wr_idx),
        .wr_val(wr_val), .apply_set(apply_set)
    );

    ledpkt_stage #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .IDX_W(IDX_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_all(wr_all), .wr_idx(wr_idx),
        .wr_val(wr_val), .apply_set(apply_set), .duty_flat(duty_flat),
        .apply_req(apply_req)
    );
endmodule

// File: tb/test_ledpkt_decoder.sv
module test_ledpkt_decoder;
    localparam int NCH = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sclk = 1'b0;
    logic           sda = 1'b0;
    logic [5:0]     dev_id = 6'h15;
    logic [NCH*7-1:0] duty_flat;
    logic           apply_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int applies = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R10";

    int exp_duty[NCH];
    bit exp_apply = 0;
    // model: 0 idle, 1 addr, 2 sub, 3 data, 4 drop, 5 burst, 6 ignore
    int m_mode = 0;
    bit m_all = 0;
    int m_idx = 0;

    always #10 clk = ~clk;

    ledpkt_decoder i_ledpkt_decoder (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sda_in(sda),
        .dev_id(dev_id), .duty_flat(duty_flat), .apply_req(apply_req)
    );

    function automatic int chan(int n);
        return int'(duty_flat[n*7 +: 7]);
    endfunction

    task automatic check(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit ok;
            ok = (apply_req == exp_apply);
            for (int i = 0; i < NCH; i++)
                if (chan(i) != exp_duty[i]) ok = 0;
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s per-cycle compare t=%0t actual_apply=%0d expected_apply=%0d ch0 actual=%0d expected=%0d",
                         cur_req, $time, apply_req, exp_apply, chan(0), exp_duty[0]);
            end
        end
    end

    always @(posedge clk) begin
        if (apply_req) applies++;
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic model_byte(input logic [7:0] b);
        int f;
        f = int'(b[5:1]);
        if (b == 8'hFF) begin
            m_mode = 1;
        end else if (b == 8'h81 && m_mode != 0 && m_mode != 6) begin
            m_mode = 0;
            exp_apply = 1;
        end else begin
            case (m_mode)
                1: m_mode = (!b[7] && (b[0] || b[6:1] == dev_id)) ? 2 : 6;
                2: begin
                    if (b[7:6] == 0 && !b[0] && f >= 1 && f <= NCH) begin
                        m_mode = 3; m_all = 0; m_idx = f - 1;
                    end else if (b == 8'h40) begin
                        m_mode = 3; m_all = 1;
                    end else if (b == 8'h60) begin
                        m_mode = 5; m_idx = 0;
                    end else m_mode = 4;
                end
                3: begin
                    if (!b[0]) begin
                        if (m_all) for (int i = 0; i < NCH; i++) exp_duty[i] = int'(b[7:1]);
                        else exp_duty[m_idx] = int'(b[7:1]);
                    end
                    m_mode = 2;
                end
                4: m_mode = 2;
                5: if (!b[0] && m_idx < NCH) begin
                    exp_duty[m_idx] = int'(b[7:1]);
                    m_idx++;
                end
                default: ;
            endcase
        end
    endtask

    task automatic send(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sda = b[i];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(posedge clk);
        #1 model_byte(b);
        @(posedge clk);
        #1 exp_apply = 0;
    endtask

    initial begin
        int a0;
        for (int i = 0; i < NCH; i++) exp_duty[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R10: reset state
        check("R10", "ch0 after reset", chan(0), 0);
        check("R10", "ch23 after reset", chan(23), 0);
        check("R10", "apply after reset", int'(apply_req), 0);

        // R1 R4 R7 R8: two pairs in one packet
        cur_req = "R4";
        a0 = applies;
        send(8'hFF); send(8'h2A); send(8'h02); send(8'h40);
        send(8'h30); send(8'hFE); send(8'h81);
        @(negedge clk);
        check("R1", "ch0 bit order", chan(0), 32);
        check("R7", "ch23 second pair", chan(23), 127);
        check("R4", "ch1 untouched", chan(1), 0);
        check("R8", "apply pulses", applies - a0, 1);

        // R3: address miss ignores everything including end byte
        cur_req = "R3";
        a0 = applies;
        send(8'hFF); send(8'h2C); send(8'h04); send(8'h10); send(8'h81);
        @(negedge clk);
        check("R3", "ch1 after miss", chan(1), 0);
        check("R3", "no apply after miss", applies - a0, 0);

        // R5 and all-call address
        cur_req = "R5";
        send(8'hFF); send(8'h4B); send(8'h40); send(8'hAA); send(8'h81);
        @(negedge clk);
        check("R5", "ch0 broadcast", chan(0), 85);
        check("R5", "ch12 broadcast", chan(12), 85);
        check("R3", "all-call reached ch23", chan(23), 85);

        // R6: full burst with two extra bytes
        cur_req = "R6";
        send(8'hFF); send(8'h2A); send(8'h60);
        for (int k = 0; k < 26; k++) send(8'((k + 1) << 1));
        send(8'h81);
        @(negedge clk);
        check("R6", "burst ch0", chan(0), 1);
        check("R6", "burst ch23 not overwritten by extras", chan(23), 24);

        // R6: short burst keeps remaining channels
        send(8'hFF); send(8'h2A); send(8'h60);
        send(8'h14); send(8'h16); send(8'h18); send(8'h81);
        @(negedge clk);
        check("R6", "short burst ch2", chan(2), 12);
        check("R6", "short burst ch3 kept", chan(3), 4);

        // R2: start byte ends a burst
        cur_req = "R2";
        send(8'hFF); send(8'h2A); send(8'h60); send(8'h22);
        send(8'hFF); send(8'h2A); send(8'h04); send(8'h0C);
        @(negedge clk);
        check("R2", "ch0 from burst", chan(0), 17);
        check("R2", "ch1 via selector after restart", chan(1), 6);
        check("R2", "ch2 not taken as burst", chan(2), 12);
        send(8'h81);

        // R9: invalid selector and odd duty dropped
        cur_req = "R9";
        send(8'hFF); send(8'h2A); send(8'h32); send(8'h10);
        send(8'h02); send(8'h11); send(8'h04); send(8'h0A); send(8'h81);
        @(negedge clk);
        check("R9", "ch7 not hit after bad selector", chan(7), 8);
        check("R9", "ch0 odd duty dropped", chan(0), 17);
        check("R9", "ch1 later pair written", chan(1), 5);

        // R8: bytes after end are ignored
        cur_req = "R8";
        a0 = applies;
        send(8'h02); send(8'h20); send(8'h81);
        @(negedge clk);
        check("R8", "ch0 after closed packet", chan(0), 17);
        check("R8", "no apply outside packet", applies - a0, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule